// File: doc/BRIEF.md
# Cache-Line-Aware Write Command Selector

This block sits in front of a DMA engine's bus master and plans the write bursts of one transfer. A transfer is loaded as a start address and a length in 32-bit dwords. For every burst the block decides whether the bus command is a plain Memory Write or a Memory Write and Invalidate, and it works out how many dwords the burst carries. It then raises a one-cycle start strobe together with the command, the length and the burst address. When the bus side reports the burst finished, the block advances its address and decrements the remaining count. It then plans the next burst from the updated state.

Memory Write and Invalidate is chosen only when five things hold at once. All three enable bits must be set. The cache line size must be a legal power of two that does not exceed the maximum burst. The FIFO must already hold a full line. The address must sit on a line boundary. In that case the burst is the largest whole number of lines that fits the available data and the maximum burst. Otherwise a plain write is issued, and it is clipped at the next line boundary so that the following burst can start aligned. The line size and the maximum burst are counted in dwords. The FIFO level is counted in bytes.

Top module: `wr_cmd_select`

## Requirements
- R1: After synchronous reset, `busy` and `burst_start` are 0.
- R2: `burst_cmd` is 4'b0111 for a plain Memory Write and 4'b1111 for Memory Write and Invalidate. No other code ever accompanies `burst_start`.
- R3: Write-and-invalidate (4'b1111) is issued only when `cls_en`, `wi_en` and `cmd_inv_en` are all 1.
- R4: Write-and-invalidate needs `line_dw` to be one of 2, 4, 8, 16, 32, 64 or 128. Any other value gives a plain write.
- R5: Write-and-invalidate needs `line_dw <= max_burst_dw`.
- R6: Write-and-invalidate needs `fifo_bytes >= 4*line_dw`. It also needs the available dwords, min(`fifo_bytes`/4, remaining), to be at least `line_dw`.
- R7: Write-and-invalidate needs the burst address to be a multiple of 4*`line_dw` bytes.
- R8: A write-and-invalidate burst carries k*`line_dw` dwords, where k is the largest integer with k*`line_dw` <= min(available, `max_burst_dw`). k is always at least 1.
- R9: A plain write burst carries min(`max_burst_dw`, available, distance in dwords to the next line boundary) dwords. The boundary term applies only when `line_dw` is legal.
- R10: `burst_start` is a single-cycle pulse. No further burst starts until `burst_done` has been seen, and the burst outputs hold steady meanwhile.
- R11: After `burst_done`, the next burst address is the previous address plus 4 times the previous length. The conditions are evaluated again for that burst. `busy` falls once the whole length has been issued.
- R12: While fewer than 4 bytes are in the FIFO, no burst starts and `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_en | input | 1 | Cache-line-size enable |
| wi_en | input | 1 | Write-and-invalidate enable |
| cmd_inv_en | input | 1 | Invalidate enable from the configuration command register |
| line_dw | input | 8 | Cache line size in dwords |
| max_burst_dw | input | 8 | Maximum burst in dwords (at least 1) |
| fifo_bytes | input | FIFO_W | Bytes currently held in the DMA FIFO |
| xfer_go | input | 1 | Load a new transfer (taken while idle) |
| xfer_addr | input | AW | Byte start address, dword aligned |
| xfer_dw | input | LEN_W | Transfer length in dwords |
| burst_done | input | 1 | Bus side finished the current burst |
| burst_start | output | 1 | One-cycle strobe for a new burst |
| burst_cmd | output | 4 | Bus command code of the burst |
| burst_dw | output | 8 | Burst length in dwords |
| burst_addr | output | AW | Byte address of the burst |
| busy | output | 1 | Transfer in progress |

## Verification
The sweep covers several kinds of line size: illegal ones (1, 3, 12), the smallest and largest legal ones, and one that exceeds the maximum burst. It crosses them with unaligned start offsets, starved and full FIFO levels, and each enable dropped in turn. A design that tested only bit 0 of the line size, or skipped the alignment check, would issue write-and-invalidate on a partial line. A design that dropped the boundary clip on plain writes would never reach alignment, and every later burst would fall back to plain writes. Multi-line bursts are checked against an arithmetic floor. An off-by-one in the multiple rounding or in the address step shows up as a wrong length or a wrong next address. A starved FIFO must stall the transfer rather than start a zero-length burst.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    localparam int LINE_W = 8;

    typedef enum logic [3:0] {
        CMD_MEM_WR     = 4'b0111,
        CMD_MEM_WR_INV = 4'b1111
    } wcs_cmd_e;

    typedef struct packed {
        wcs_cmd_e          cmd;
        logic [LINE_W-1:0] len_dw;
    } wcs_burst_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PLAN = 2'd1,
        ST_WAIT = 2'd2
    } wcs_state_e;

    function automatic logic line_is_legal(input logic [LINE_W-1:0] v);
        case (v)
            8'd2, 8'd4, 8'd8, 8'd16, 8'd32, 8'd64, 8'd128: return 1'b1;
            default:                                      return 1'b0;
        endcase
    endfunction

    function automatic logic [LINE_W-1:0] min_dw(input logic [LINE_W-1:0] a,
                                                 input logic [LINE_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/wcs_qualify.sv
module wcs_qualify
    import wcs_pkg::*;
#(
    parameter int AW     = 32,
    parameter int FIFO_W = 12,
    parameter int AV_W   = 12
) (
    input  logic              cls_en,
    input  logic              wi_en,
    input  logic              cmd_inv_en,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [LINE_W-1:0] max_burst_dw,
    input  logic [FIFO_W-1:0] fifo_bytes,
    input  logic [AV_W-1:0]   avail_dw,
    input  logic [AW-1:0]     cur_addr,
    output logic              line_legal,
    output logic              inv_ok,
    output logic [LINE_W-1:0] dist_dw
);
    localparam int PAD = FIFO_W - LINE_W - 2;

    logic [LINE_W-1:0] line_mask;
    logic [LINE_W-1:0] offset_dw;
    logic [FIFO_W-1:0] line_bytes;
    logic              enables_set;
    logic              fits_max;
    logic              has_data;
    logic              aligned;

    always_comb begin
        line_legal  = line_is_legal(line_dw);
        line_mask   = line_dw - 8'd1;
        offset_dw   = cur_addr[LINE_W+1:2] & line_mask;
        dist_dw     = line_dw - offset_dw;
        line_bytes  = {{PAD{1'b0}}, line_dw, 2'b00};
        enables_set = cls_en & wi_en & cmd_inv_en;
        fits_max    = (line_dw <= max_burst_dw);
        has_data    = (fifo_bytes >= line_bytes) && (avail_dw >= AV_W'(line_dw));
        aligned     = (offset_dw == '0);
        inv_ok      = enables_set & line_legal & fits_max & has_data & aligned;
    end

endmodule

// File: rtl/wcs_sizer.sv
module wcs_sizer
    import wcs_pkg::*;
#(
    parameter int AV_W = 12
) (
    input  logic              line_legal,
    input  logic              inv_ok,
    input  logic [LINE_W-1:0] line_dw,
    input  logic [LINE_W-1:0] max_burst_dw,
    input  logic [LINE_W-1:0] dist_dw,
    input  logic [AV_W-1:0]   avail_dw,
    output wcs_burst_t        plan
);
    logic [LINE_W-1:0] cap_dw;
    logic [LINE_W-1:0] plain_dw;

    always_comb begin
        if (avail_dw < AV_W'(max_burst_dw)) begin
            cap_dw = avail_dw[LINE_W-1:0];
        end else begin
            cap_dw = max_burst_dw;
        end
        plain_dw = line_legal ? min_dw(cap_dw, dist_dw) : cap_dw;
        if (inv_ok) begin
            plan.cmd    = CMD_MEM_WR_INV;
            plan.len_dw = cap_dw & ~(line_dw - 8'd1);
        end else begin
            plan.cmd    = CMD_MEM_WR;
            plan.len_dw = plain_dw;
        end
    end

endmodule

// File: rtl/wcs_seq.sv
module wcs_seq
    import wcs_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_go,
    input  logic [AW-1:0]    xfer_addr,
    input  logic [LEN_W-1:0] xfer_dw,
    input  logic             burst_done,
    input  wcs_burst_t       plan,
    output logic [AW-1:0]    cur_addr,
    output logic [LEN_W-1:0] cur_rem,
    output wcs_burst_t       issued,
    output logic             burst_start,
    output logic             busy
);
    wcs_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_addr    <= '0;
            cur_rem     <= '0;
            issued      <= '{cmd: CMD_MEM_WR, len_dw: '0};
            burst_start <= 1'b0;
        end else begin
            burst_start <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (xfer_go && xfer_dw != '0) begin
                        cur_addr <= {xfer_addr[AW-1:2], 2'b00};
                        cur_rem  <= xfer_dw;
                        state_q  <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (plan.len_dw != '0) begin
                        issued      <= plan;
                        burst_start <= 1'b1;
                        state_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (burst_done) begin
                        cur_addr <= cur_addr + AW'({issued.len_dw, 2'b00});
                        cur_rem  <= cur_rem - LEN_W'(issued.len_dw);
                        state_q  <= (cur_rem == LEN_W'(issued.len_dw)) ? ST_IDLE : ST_PLAN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/wr_cmd_select.sv
module wr_cmd_select
    import wcs_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_W  = 12,
    parameter int FIFO_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cls_en,
    input  logic              wi_en,
    input  logic              cmd_inv_en,
    input  logic [7:0]        line_dw,
    input  logic [7:0]        max_burst_dw,
    input  logic [FIFO_W-1:0] fifo_bytes,
    input  logic              xfer_go,
    input  logic [AW-1:0]     xfer_addr,
    input  logic [LEN_W-1:0]  xfer_dw,
    input  logic              burst_done,
    output logic              burst_start,
    output logic [3:0]        burst_cmd,
    output logic [7:0]        burst_dw,
    output logic [AW-1:0]     burst_addr,
    output logic              busy
);
    localparam int FDW_W = FIFO_W - 2;
    localparam int AV_W  = (LEN_W > FDW_W) ? LEN_W : FDW_W;

    logic [AW-1:0]     cur_addr;
    logic [LEN_W-1:0]  cur_rem;
    logic [AV_W-1:0]   fifo_dw;
    logic [AV_W-1:0]   rem_dw;
    logic [AV_W-1:0]   avail_dw;
    logic              line_legal;
    logic              inv_ok;
    logic [LINE_W-1:0] dist_dw;
    wcs_burst_t        plan;
    wcs_burst_t        issued;
    logic [AW-1:0]     addr_hold;

    always_comb begin
        fifo_dw  = AV_W'(fifo_bytes[FIFO_W-1:2]);
        rem_dw   = AV_W'(cur_rem);
        avail_dw = (fifo_dw < rem_dw) ? fifo_dw : rem_dw;
    end

    wcs_qualify #(.AW(AW), .FIFO_W(FIFO_W), .AV_W(AV_W)) u_qual (
        .cls_en       (cls_en),
        .wi_en        (wi_en),
        .cmd_inv_en   (cmd_inv_en),
        .line_dw      (line_dw),
        .max_burst_dw (max_burst_dw),
        .fifo_bytes   (fifo_bytes),
        .avail_dw     (avail_dw),
        .cur_addr     (cur_addr),
        .line_legal   (line_legal),
        .inv_ok       (inv_ok),
        .dist_dw      (dist_dw)
    );

    wcs_sizer #(.AV_W(AV_W)) u_size (
        .line_legal   (line_legal),
        .inv_ok       (inv_ok),
        .line_dw      (line_dw),
        .max_burst_dw (max_burst_dw),
        .dist_dw      (dist_dw),
        .avail_dw     (avail_dw),
        .plan         (plan)
    );

    wcs_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .xfer_go     (xfer_go),
        .xfer_addr   (xfer_addr),
        .xfer_dw     (xfer_dw),
        .burst_done  (burst_done),
        .plan        (plan),
        .cur_addr    (cur_addr),
        .cur_rem     (cur_rem),
        .issued      (issued),
        .burst_start (burst_start),
        .busy        (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_hold <= '0;
        end else if (u_seq.state_q == ST_PLAN && plan.len_dw != '0) begin
            addr_hold <= cur_addr;
        end
    end

    assign burst_cmd  = issued.cmd;
    assign burst_dw   = issued.len_dw;
    assign burst_addr = addr_hold;

endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
    parameter int AW     = 32,
    parameter int FIFO_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cls_en,
    input logic              wi_en,
    input logic              cmd_inv_en,
    input logic [7:0]        line_dw,
    input logic [7:0]        max_burst_dw,
    input logic [FIFO_W-1:0] fifo_bytes,
    input logic              burst_done,
    input logic              burst_start,
    input logic [3:0]        burst_cmd,
    input logic [7:0]        burst_dw,
    input logic [AW-1:0]     burst_addr,
    input logic              busy
);
    logic inv_now;
    assign inv_now = burst_start && (burst_cmd == 4'b1111);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !burst_start);

    assert_cmd_code_R2: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> (burst_cmd == 4'b0111 || burst_cmd == 4'b1111));

    assert_inv_enables_R3: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> (cls_en && wi_en && cmd_inv_en));

    assert_inv_legal_line_R4: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> ($countones(line_dw) == 1 && line_dw >= 8'd2));

    assert_inv_le_max_R5: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> (line_dw <= max_burst_dw));

    assert_inv_fifo_R6: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> ($past(fifo_bytes) >= FIFO_W'({line_dw, 2'b00})));

    assert_inv_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> ((burst_addr[9:2] & (line_dw - 8'd1)) == 8'd0));

    assert_inv_whole_lines_R8: assert property (@(posedge clk) disable iff (rst)
        inv_now |-> (burst_dw >= line_dw && (burst_dw & (line_dw - 8'd1)) == 8'd0));

    assert_len_bounds_R9: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> (burst_dw != 8'd0 && burst_dw <= max_burst_dw));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start);

    assert_hold_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !burst_start && !$past(burst_done)) |-> ($stable(burst_addr) && $stable(burst_dw)));

endmodule

bind wr_cmd_select wcs_checker #(.AW(AW), .FIFO_W(FIFO_W)) u_wcs_chk (
    .clk          (clk),
    .rst          (rst),
    .cls_en       (cls_en),
    .wi_en        (wi_en),
    .cmd_inv_en   (cmd_inv_en),
    .line_dw      (line_dw),
    .max_burst_dw (max_burst_dw),
    .fifo_bytes   (fifo_bytes),
    .burst_done   (burst_done),
    .burst_start  (burst_start),
    .burst_cmd    (burst_cmd),
    .burst_dw     (burst_dw),
    .burst_addr   (burst_addr),
    .busy         (busy)
);

// File: tb/wr_cmd_select_test.sv
module wr_cmd_select_test;
    localparam int AW     = 32;
    localparam int LEN_W  = 12;
    localparam int FIFO_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cls_en = 1'b0;
    logic              wi_en = 1'b0;
    logic              cmd_inv_en = 1'b0;
    logic [7:0]        line_dw = 8'd0;
    logic [7:0]        max_burst_dw = 8'd1;
    logic [FIFO_W-1:0] fifo_bytes = '0;
    logic              xfer_go = 1'b0;
    logic [AW-1:0]     xfer_addr = '0;
    logic [LEN_W-1:0]  xfer_dw = '0;
    logic              burst_done = 1'b0;
    logic              burst_start;
    logic [3:0]        burst_cmd;
    logic [7:0]        burst_dw;
    logic [AW-1:0]     burst_addr;
    logic              busy;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wr_cmd_select #(.AW(AW), .LEN_W(LEN_W), .FIFO_W(FIFO_W)) uut (
        .clk(clk), .rst(rst), .cls_en(cls_en), .wi_en(wi_en), .cmd_inv_en(cmd_inv_en),
        .line_dw(line_dw), .max_burst_dw(max_burst_dw), .fifo_bytes(fifo_bytes),
        .xfer_go(xfer_go), .xfer_addr(xfer_addr), .xfer_dw(xfer_dw),
        .burst_done(burst_done), .burst_start(burst_start), .burst_cmd(burst_cmd),
        .burst_dw(burst_dw), .burst_addr(burst_addr), .busy(busy)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal(input int l);
        return (l == 2 || l == 4 || l == 8 || l == 16 || l == 32 || l == 64 || l == 128);
    endfunction

    function automatic void model(input bit e1, input bit e2, input bit e3, input int line,
                                  input int maxb, input int fifo, input int rem, input longint addr,
                                  output int ecmd, output int elen, output string why);
        int avail;
        int off;
        int cap;
        avail = (fifo / 4 < rem) ? fifo / 4 : rem;
        off   = legal(line) ? int'((addr / 4) % line) : 0;
        cap   = (avail < maxb) ? avail : maxb;
        if (!(e1 && e2 && e3))                           why = "R3";
        else if (!legal(line))                           why = "R4";
        else if (line > maxb)                            why = "R5";
        else if (fifo < 4 * line || avail < line)        why = "R6";
        else if (off != 0)                               why = "R7";
        else                                             why = "R8";
        if (why == "R8") begin
            ecmd = 15;
            elen = (cap / line) * line;
        end else begin
            ecmd = 7;
            elen = cap;
            if (legal(line) && (line - off) < elen) elen = line - off;
        end
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; burst_done = 1'b0; xfer_go = 1'b0;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic launch(input longint a, input int r);
        @(negedge clk);
        xfer_addr = AW'(a); xfer_dw = LEN_W'(r); xfer_go = 1'b1;
        @(negedge clk);
        xfer_go = 1'b0;
    endtask

    task automatic wait_start(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (burst_start) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic finish_done();
        burst_done = 1'b1;
        @(negedge clk);
        burst_done = 1'b0;
    endtask

    task automatic run_xfer(input bit e1, input bit e2, input bit e3, input int line,
                            input int maxb, input int fifo, input longint a0, input int r0);
        longint a;
        int r;
        int ecmd, elen;
        string why;
        bit ok;
        cls_en = e1; wi_en = e2; cmd_inv_en = e3;
        line_dw = 8'(line); max_burst_dw = 8'(maxb); fifo_bytes = FIFO_W'(fifo);
        launch(a0, r0);
        a = a0; r = r0;
        while (r > 0) begin
            wait_start(ok);
            chk("R11", "burst started", ok, 1);
            if (!ok) begin do_reset(); return; end
            model(e1, e2, e3, line, maxb, fifo, r, a, ecmd, elen, why);
            chk(why, "command", burst_cmd, ecmd);
            chk((ecmd == 15) ? "R8" : "R9", "length", burst_dw, elen);
            chk("R11", "address", burst_addr, a);
            a = a + 4 * burst_dw;
            r = r - burst_dw;
            if (burst_dw == 0) r = 0;
            finish_done();
        end
        chk("R11", "busy after last burst", busy, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        int lines[8] = '{1, 2, 3, 4, 12, 8, 32, 128};
        int maxbs[3] = '{1, 8, 64};
        int fifos[3] = '{6, 40, 600};
        int offs[3]  = '{0, 1, 5};
        int rems[3]  = '{3, 20, 70};

        do_reset();
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "burst_start after reset", burst_start, 0);

        // R10 and R2: pulse width and hold while done is withheld, enables off
        cls_en = 0; wi_en = 0; cmd_inv_en = 0;
        line_dw = 8'd8; max_burst_dw = 8'd16; fifo_bytes = FIFO_W'(200);
        launch(64'h2000, 10);
        wait_start(ok);
        chk("R10", "first strobe", ok, 1);
        chk("R2", "plain write code", burst_cmd, 4'b0111);
        chk("R9", "clipped to one line", burst_dw, 8);
        @(negedge clk);
        chk("R10", "strobe is one cycle", burst_start, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10", "no strobe before done", burst_start, 0);
            chk("R10", "address held", burst_addr, 32'h2000);
        end
        finish_done();
        wait_start(ok);
        chk("R11", "second burst address", burst_addr, 32'h2020);
        chk("R11", "second burst length", burst_dw, 2);
        finish_done();
        chk("R11", "idle after transfer", busy, 0);

        // R12: starved FIFO stalls
        cls_en = 1; wi_en = 1; cmd_inv_en = 1;
        line_dw = 8'd4; max_burst_dw = 8'd16; fifo_bytes = FIFO_W'(2);
        launch(64'h3000, 8);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R12", "no strobe while starved", burst_start, 0);
        end
        chk("R12", "busy while starved", busy, 1);
        fifo_bytes = FIFO_W'(64);
        wait_start(ok);
        chk("R12", "strobe after data arrives", ok, 1);
        chk("R2", "invalidate code", burst_cmd, 4'b1111);
        chk("R8", "two lines", burst_dw, 8);
        finish_done();

        // Sweep over configuration space
        for (int es = 0; es < 2; es++)
            for (int li = 0; li < 8; li++)
                for (int mi = 0; mi < 3; mi++)
                    for (int fi = 0; fi < 3; fi++)
                        for (int oi = 0; oi < 3; oi++)
                            for (int ri = 0; ri < 3; ri++) begin
                                bit e1, e2, e3;
                                e1 = !(es == 1 && li % 3 == 0);
                                e2 = !(es == 1 && li % 3 == 1);
                                e3 = !(es == 1 && li % 3 == 2);
                                run_xfer(e1, e2, e3, lines[li], maxbs[mi], fifos[fi],
                                         64'h1000 + 4 * offs[oi], rems[ri]);
                            end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule